// File: doc/BRIEF.md
# Flash program pulse sequencer

This block produces the timed sequence of control levels that applies one programming pulse to a flash array. A loop sequencer raises a request and supplies a 2-bit width code. The block then drives three outputs in a fixed order. It turns on the watchdog enable, then raises program-setup. After a setup wait it raises the program strobe for the selected width. It drops the strobe and waits, drops program-setup and waits again. Finally it clears the watchdog enable and acknowledges for one cycle.

Every wait is a parameter given in microseconds. The parameter `CYC_PER_US` turns each wait into a clock-cycle count at elaboration. The three pulse widths are also parameters in microseconds. The default widths are 10 µs for additional-programming writes, 30 µs for early loop passes and 200 µs for late passes. The loop sequencer decides which width each pulse gets. This block only decodes the code and times the sequence.

Top module: `flash_pulse_timer`

## Requirements
- R1: While `rst_n` is low, all four outputs are low. This holds even when reset arrives in the middle of a sequence, because the reset is asynchronous. After release the block is idle.
- R2: A request (`req_i` high at a rising edge while idle) starts a sequence. `wdt_en_o` is high from the next cycle on. `psu_o` stays low for the first T_WDT_LEAD_US×CYC_PER_US cycles.
- R3: `psu_o` is high for T_PSU_SETUP_US×CYC_PER_US cycles before `prog_o` rises.
- R4: `prog_o` is high for exactly W×CYC_PER_US cycles. W depends on the width code: code 0 gives PW_EXTRA_US (10 µs), code 1 gives PW_EARLY_US (30 µs), and codes 2 and 3 give PW_LATE_US (200 µs).
- R5: After `prog_o` falls, `psu_o` stays high for T_P_HOLD_US×CYC_PER_US cycles and then falls.
- R6: After `psu_o` falls, `wdt_en_o` stays high for T_PSU_HOLD_US×CYC_PER_US cycles. It then falls in the same cycle in which `ack_o` rises.
- R7: `ack_o` is high for exactly one cycle per sequence. All other outputs are low in that cycle.
- R8: `prog_o` is never high unless `psu_o` is high. `psu_o` is never high unless `wdt_en_o` is high.
- R9: Changes on `req_i` and `width_sel_i` while a sequence runs have no effect. The width code is captured when the request is accepted.
- R10: The acknowledge cycle counts as idle. If `req_i` is high in that cycle, the next sequence starts at once, and `wdt_en_o` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Pulse request, sampled while idle |
| width_sel_i | input | 2 | Width code: 0 = extra, 1 = early, 2/3 = late |
| ack_o | output | 1 | One-cycle end-of-sequence acknowledge |
| psu_o | output | 1 | Program-setup level |
| prog_o | output | 1 | Program strobe |
| wdt_en_o | output | 1 | Watchdog enable bracketing the sequence |

## Verification
The end of one sequence and the start of the next can fall in the same cycle. In the acknowledge cycle the block is already idle and can accept a new request. The bench provokes this by keeping `req_i` high through the acknowledge cycle. It then checks that `wdt_en_o` is low for exactly that one cycle and rises in the next. The whole per-cycle trace of the second sequence is compared against a timeline computed from the parameters. Separately, random toggling of the request and width code during running sequences must leave every traced cycle unchanged.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SETUP = 3'd2,
        ST_PULSE = 3'd3,
        ST_PHOLD = 3'd4,
        ST_SHOLD = 3'd5
    } seq_state_e;

    localparam int unsigned WSEL_W = 2;

    typedef enum logic [WSEL_W-1:0] {
        WSEL_EXTRA = 2'd0,
        WSEL_EARLY = 2'd1,
        WSEL_LATE  = 2'd2,
        WSEL_LATE2 = 2'd3
    } wsel_e;

    typedef struct packed {
        seq_state_e        state;
        logic [WSEL_W-1:0] wsel;
        logic              wdt;
        logic              psu;
        logic              prog;
        logic              ack;
    } seq_regs_t;

    // microseconds to clock cycles, never below one cycle
    function automatic int unsigned us_to_cycles(int unsigned us, int unsigned cpu);
        int unsigned c;
        c = us * cpu;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpt_wait_counter.sv
module fpt_wait_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpt_width_lut.sv
module fpt_width_lut
    import fpt_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned EXTRA_CYC = 10,
    parameter int unsigned EARLY_CYC = 30,
    parameter int unsigned LATE_CYC  = 200
) (
    input  logic [WSEL_W-1:0] code_i,
    output logic [CW-1:0]     cycles_o
);
    always_comb begin
        case (code_i)
            WSEL_EXTRA: cycles_o = CW'(EXTRA_CYC);
            WSEL_EARLY: cycles_o = CW'(EARLY_CYC);
            default:    cycles_o = CW'(LATE_CYC);
        endcase
    end
endmodule

// File: rtl/fpt_seq_fsm.sv
module fpt_seq_fsm
    import fpt_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned LEAD_CYC  = 4,
    parameter int unsigned SETUP_CYC = 8,
    parameter int unsigned PHOLD_CYC = 8,
    parameter int unsigned SHOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [WSEL_W-1:0] width_sel_i,
    input  logic [CW-1:0]     pulse_cycles_i,
    input  logic              wait_done_i,
    output logic [WSEL_W-1:0] wsel_o,
    output logic              load_o,
    output logic [CW-1:0]     load_val_o,
    output logic              wdt_o,
    output logic              psu_o,
    output logic              prog_o,
    output logic              ack_o
);
    localparam logic [CW-1:0] LEAD_LD  = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PHOLD_LD = CW'(PHOLD_CYC - 1);
    localparam logic [CW-1:0] SHOLD_LD = CW'(SHOLD_CYC - 1);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.state  = ST_LEAD;
                    r_d.wsel   = width_sel_i;
                    r_d.wdt    = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = LEAD_LD;
                end
            end
            ST_LEAD: begin
                if (wait_done_i) begin
                    r_d.state  = ST_SETUP;
                    r_d.psu    = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (wait_done_i) begin
                    r_d.state  = ST_PULSE;
                    r_d.prog   = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = pulse_cycles_i - 1'b1;
                end
            end
            ST_PULSE: begin
                if (wait_done_i) begin
                    r_d.state  = ST_PHOLD;
                    r_d.prog   = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = PHOLD_LD;
                end
            end
            ST_PHOLD: begin
                if (wait_done_i) begin
                    r_d.state  = ST_SHOLD;
                    r_d.psu    = 1'b0;
                    load_o     = 1'b1;
                    load_val_o = SHOLD_LD;
                end
            end
            ST_SHOLD: begin
                if (wait_done_i) begin
                    r_d.state = ST_IDLE;
                    r_d.wdt   = 1'b0;
                    r_d.ack   = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.wdt   = 1'b0;
                r_d.psu   = 1'b0;
                r_d.prog  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, wsel: '0, wdt: 1'b0, psu: 1'b0, prog: 1'b0, ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wsel_o = r_q.wsel;
    assign wdt_o  = r_q.wdt;
    assign psu_o  = r_q.psu;
    assign prog_o = r_q.prog;
    assign ack_o  = r_q.ack;
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer
    import fpt_pkg::*;
#(
    parameter int unsigned CYC_PER_US     = 4,
    parameter int unsigned T_WDT_LEAD_US  = 1,
    parameter int unsigned T_PSU_SETUP_US = 2,
    parameter int unsigned T_P_HOLD_US    = 2,
    parameter int unsigned T_PSU_HOLD_US  = 1,
    parameter int unsigned PW_EXTRA_US    = 10,
    parameter int unsigned PW_EARLY_US    = 30,
    parameter int unsigned PW_LATE_US     = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [WSEL_W-1:0] width_sel_i,
    output logic              ack_o,
    output logic              psu_o,
    output logic              prog_o,
    output logic              wdt_en_o
);
    localparam int unsigned LEAD_CYC  = us_to_cycles(T_WDT_LEAD_US, CYC_PER_US);
    localparam int unsigned SETUP_CYC = us_to_cycles(T_PSU_SETUP_US, CYC_PER_US);
    localparam int unsigned PHOLD_CYC = us_to_cycles(T_P_HOLD_US, CYC_PER_US);
    localparam int unsigned SHOLD_CYC = us_to_cycles(T_PSU_HOLD_US, CYC_PER_US);
    localparam int unsigned EXTRA_CYC = us_to_cycles(PW_EXTRA_US, CYC_PER_US);
    localparam int unsigned EARLY_CYC = us_to_cycles(PW_EARLY_US, CYC_PER_US);
    localparam int unsigned LATE_CYC  = us_to_cycles(PW_LATE_US, CYC_PER_US);
    localparam int unsigned MAX_WAIT  = max2(max2(LEAD_CYC, SETUP_CYC), max2(PHOLD_CYC, SHOLD_CYC));
    localparam int unsigned MAX_PULSE = max2(max2(EXTRA_CYC, EARLY_CYC), LATE_CYC);
    localparam int unsigned CW        = $clog2(max2(MAX_WAIT, MAX_PULSE) + 1);

    logic [WSEL_W-1:0] wsel_q;
    logic [CW-1:0]     pulse_cycles;
    logic              cnt_load;
    logic [CW-1:0]     cnt_load_val;
    logic              cnt_zero;

    fpt_width_lut #(
        .CW        (CW),
        .EXTRA_CYC (EXTRA_CYC),
        .EARLY_CYC (EARLY_CYC),
        .LATE_CYC  (LATE_CYC)
    ) i_width_lut (
        .code_i   (wsel_q),
        .cycles_o (pulse_cycles)
    );

    fpt_wait_counter #(
        .CW (CW)
    ) i_wait_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .zero_o     (cnt_zero)
    );

    fpt_seq_fsm #(
        .CW        (CW),
        .LEAD_CYC  (LEAD_CYC),
        .SETUP_CYC (SETUP_CYC),
        .PHOLD_CYC (PHOLD_CYC),
        .SHOLD_CYC (SHOLD_CYC)
    ) i_seq_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .width_sel_i    (width_sel_i),
        .pulse_cycles_i (pulse_cycles),
        .wait_done_i    (cnt_zero),
        .wsel_o         (wsel_q),
        .load_o         (cnt_load),
        .load_val_o     (cnt_load_val),
        .wdt_o          (wdt_en_o),
        .psu_o          (psu_o),
        .prog_o         (prog_o),
        .ack_o          (ack_o)
    );
endmodule

// File: rtl/flash_pulse_timer_chk.sv
module flash_pulse_timer_chk
    import fpt_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 4,
    parameter int unsigned PW_EXTRA_US = 10,
    parameter int unsigned PW_EARLY_US = 30,
    parameter int unsigned PW_LATE_US  = 200
) (
    input logic clk,
    input logic rst_n,
    input logic ack_o,
    input logic psu_o,
    input logic prog_o,
    input logic wdt_en_o
);
    localparam int unsigned W_X = us_to_cycles(PW_EXTRA_US, CYC_PER_US);
    localparam int unsigned W_E = us_to_cycles(PW_EARLY_US, CYC_PER_US);
    localparam int unsigned W_L = us_to_cycles(PW_LATE_US, CYC_PER_US);

    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else begin
            hi_cnt <= prog_o ? hi_cnt + 1 : 0;
        end
    end

    a_r8_prog_needs_psu: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |-> psu_o);
    a_r8_psu_needs_wdt: assert property (@(posedge clk) disable iff (!rst_n)
        psu_o |-> wdt_en_o);
    a_r2_wdt_before_psu: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psu_o) |-> $past(wdt_en_o));
    a_r3_psu_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_o) |-> $past(psu_o));
    a_r5_prog_low_before_psu_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psu_o) |-> !$past(prog_o));
    a_r6_wdt_drop_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_en_o) |-> ack_o);
    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    a_r4_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_o) |-> (hi_cnt == W_X || hi_cnt == W_E || hi_cnt == W_L));
endmodule

bind flash_pulse_timer flash_pulse_timer_chk #(
    .CYC_PER_US  (CYC_PER_US),
    .PW_EXTRA_US (PW_EXTRA_US),
    .PW_EARLY_US (PW_EARLY_US),
    .PW_LATE_US  (PW_LATE_US)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_o    (ack_o),
    .psu_o    (psu_o),
    .prog_o   (prog_o),
    .wdt_en_o (wdt_en_o)
);

// File: tb/test_flash_pulse_timer.sv
`timescale 1ns/1ps
module test_flash_pulse_timer;
    localparam int CPU   = 4;
    localparam int LEAD  = 1 * CPU;
    localparam int SETUP = 2 * CPU;
    localparam int PHOLD = 2 * CPU;
    localparam int SHOLD = 1 * CPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] wsel = 2'd0;
    logic       ack, psu, prog, wdt;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    flash_pulse_timer i_flash_pulse_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .width_sel_i (wsel),
        .ack_o       (ack),
        .psu_o       (psu),
        .prog_o      (prog),
        .wdt_en_o    (wdt)
    );

    // expected widths in cycles (R4): 0 -> 10 us, 1 -> 30 us, 2/3 -> 200 us
    function automatic int width_cyc(logic [1:0] code);
        case (code)
            2'd0:    return 10 * CPU;
            2'd1:    return 30 * CPU;
            default: return 200 * CPU;
        endcase
    endfunction

    // {ack, wdt, psu, prog} in cycle t after the accepting edge
    function automatic logic [3:0] exp_vec(int t, int w);
        int a, b, c, d, e;
        a = LEAD; b = a + SETUP; c = b + w; d = c + PHOLD; e = d + SHOLD;
        if (t < a)      return 4'b0100;
        else if (t < b) return 4'b0110;
        else if (t < c) return 4'b0111;
        else if (t < d) return 4'b0110;
        else if (t < e) return 4'b0100;
        else            return 4'b1000;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8: invariant checked every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(prog && !psu), "R8 prog without psu", {prog, psu}, 2'b11);
            check(!(psu && !wdt), "R8 psu without wdt", {psu, wdt}, 2'b11);
        end
    end

    task automatic idle_gap(input int n);
        bit ok = 1'b1;
        logic [3:0] bad = 4'b0;
        req = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ({ack, wdt, psu, prog} !== 4'b0000 && ok) begin
                ok = 1'b0;
                bad = {ack, wdt, psu, prog};
            end
        end
        check(ok, "R7/R9 idle outputs", bad, 4'b0000);
    endtask

    // called at a negedge; returns at the negedge of the acknowledge cycle
    task automatic run_pulse(input logic [1:0] code, input bit noisy, input bit chain, input string tag);
        int w, total, bad_t;
        bit ok;
        logic [3:0] act, exp, got;
        w = width_cyc(code);
        total = LEAD + SETUP + w + PHOLD + SHOLD;
        ok = 1'b1; bad_t = 0; act = '0; exp = '0;
        req = 1'b1;
        wsel = code;
        @(posedge clk);
        for (int t = 0; t <= total; t++) begin
            @(negedge clk);
            got = {ack, wdt, psu, prog};
            if (got !== exp_vec(t, w) && ok) begin
                ok = 1'b0; bad_t = t; act = got; exp = exp_vec(t, w);
            end
            if (t < total) begin
                if (noisy) begin
                    req = 1'($urandom);
                    wsel = 2'($urandom);
                end else begin
                    req = 1'b0;
                end
            end else begin
                req = chain;
            end
        end
        if (!ok) $display("FAIL %s trace mismatch at cycle %0d code %0d", tag, bad_t, code);
        check(ok, tag, act, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({ack, wdt, psu, prog} === 4'b0000, "R1 outputs in reset", {ack, wdt, psu, prog}, 4'b0000);
        rst_n = 1'b1;
        idle_gap(3);

        // directed: each width code (R2..R7)
        run_pulse(2'd0, 1'b0, 1'b0, "R2/R3/R4/R5/R6/R7 code0 10us"); idle_gap(2);
        run_pulse(2'd1, 1'b0, 1'b0, "R2/R3/R4/R5/R6/R7 code1 30us"); idle_gap(2);
        run_pulse(2'd2, 1'b0, 1'b0, "R4 code2 200us");                idle_gap(2);
        run_pulse(2'd3, 1'b0, 1'b0, "R4 code3 200us");                idle_gap(2);

        // noise on req and width while running (R9)
        run_pulse(2'd0, 1'b1, 1'b0, "R9 noisy code0"); idle_gap(1);
        run_pulse(2'd1, 1'b1, 1'b0, "R9 noisy code1"); idle_gap(1);

        // back-to-back via acknowledge cycle (R10)
        run_pulse(2'd1, 1'b0, 1'b1, "R10 first of chain");
        run_pulse(2'd0, 1'b0, 1'b1, "R10 second of chain");
        run_pulse(2'd0, 1'b0, 1'b0, "R10 third of chain");
        idle_gap(2);

        // reset in the middle of a pulse (R1)
        req = 1'b1; wsel = 2'd1;
        @(negedge clk);
        req = 1'b0;
        repeat (LEAD + SETUP + 5) @(negedge clk);
        check(prog === 1'b1, "R1 pulse running before reset", prog, 1'b1);
        rst_n = 1'b0;
        #1;
        check({ack, wdt, psu, prog} === 4'b0000, "R1 async reset mid pulse", {ack, wdt, psu, prog}, 4'b0000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle_gap(3);
        run_pulse(2'd0, 1'b0, 1'b0, "R1 pulse after reset"); idle_gap(1);

        // constrained random mix
        for (int k = 0; k < 24; k++) begin
            logic [1:0] c;
            bit nz, ch;
            c  = 2'($urandom % 4);
            nz = 1'($urandom);
            ch = (($urandom % 3) == 0);
            run_pulse(c, nz, ch, "R4/R9/R10 random");
            if (!ch) idle_gap(1 + int'($urandom % 3));
        end
        idle_gap(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule